// File: doc/BRIEF.md
# Table-Driven Multi-Level Memory Arbiter

This block decides which of up to 32 requesting agents may use a shared memory port next. The order of service is set by tables that software writes: a timing wheel of slot owners, a strict priority list and two round-robin lists. Each table has its own count of valid entries. Any count larger than its table is treated as the full table. Two complete copies of the tables and counts exist. An input picks the copy that the next arbitration uses, so software can rewrite one copy while the other is in service.

A grant is registered. It drives a one-hot vector and the agent number, and it holds until the consumer pulses `accept`. On the accepting edge the grant drops, and the wheel and round-robin pointers step. A new arbitration runs in the following cycle, so a granted agent can be served at most every second cycle.

The table port uses word addresses. Bit 8 selects copy 0 or copy 1. The low byte selects the register within that copy:

| Low byte | Contents |
|---|---|
| 0x00–0x7F | wheel slots |
| 0x80–0x8F | priority list |
| 0x90–0x9F | round-robin list 1 |
| 0xA0–0xA7 | round-robin list 2 |
| 0xC0 | count word |

Top module: `marb_top`

## Requirements
- R1: After reset there is no grant, `cfg_rdata` reads zero, and every valid count is zero. Requests therefore produce no grant until software programs a count.
- R2: Levels are served in a fixed order, and the first level with a requesting entry wins: the wheel owner of the current slot, then the priority list, then round-robin list 1, then round-robin list 2.
- R3: The wheel slot pointer moves only on an accepted grant. It steps by one on every accepted grant from any level, and returns to slot 0 when it reaches the wheel count. A wheel count of zero disables the wheel level.
- R4: In the priority list, the requesting entry with the lowest index wins. Entries at or above the priority count are never considered.
- R5: Round-robin list 1 searches from its own pointer and wraps at its count. After a grant from this list, the pointer is set to the entry after the granted one. Entries at or above the count are skipped.
- R6: Round-robin list 2 behaves as R5, with a pointer that is independent of list 1.
- R7: The count fields are clamped. A wheel count above 128 uses 128 slots. A priority count or list-1 count above 16 uses 16 entries. A list-2 count above 8 uses 8 entries.
- R8: Each entry holds a 2-bit qualifier in bits 9:8. Every code, including the reserved codes 1 to 3, grants without regard to `req_wr`, so `req_wr` never changes the result.
- R9: Two table copies exist. `set_sel` (0 = copy 0, 1 = copy 1) is looked at only in a cycle with no grant outstanding.
- R10: `grant` is one-hot and matches `grant_id` while `grant_valid` is high. The grant stays unchanged until `accept`, and it drops on the edge that samples `accept`.
- R11: If no listed agent requests, no grant is made.
- R12: Entry words read back the agent ID in bits 4:0 and the qualifier in bits 9:8. The count word reads back as follows: list-2 count in bits 3:0, list-1 count in bits 12:8, priority count in bits 20:16, wheel count in bits 31:24. All other bits and unmapped addresses read zero. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_AGENTS | Request per agent |
| req_wr | input | N_AGENTS | Per-agent write indication (1 = write) |
| set_sel | input | 1 | Table copy used for the next arbitration |
| accept | input | 1 | Consumer takes the current grant |
| grant | output | N_AGENTS | One-hot grant |
| grant_valid | output | 1 | A grant is outstanding |
| grant_id | output | 5 | Number of the granted agent |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 9 | Table word address |
| cfg_wdata | input | 32 | Table write data |
| cfg_rdata | output | 32 | Table read data, registered |

## Verification
A wrong internal pointer shows up in the grant, not in a status output. A wheel pointer that is off by one hands the next accepted grant to the wrong slot owner. A round-robin pointer left on the old entry makes that list repeat an agent on its very next grant. So every pointer fault appears in `grant_id` within one grant of its cause. A count clamped wrongly, or a stale copy select, shows in the first arbitration after the write or switch: that arbitration either picks an agent outside the programmed range or makes no grant at all.

// File: rtl/marb_pkg.sv
package marb_pkg;
  localparam int AID_W  = 5;
  localparam int QUAL_W = 2;
  localparam int CFG_AW = 9;

  typedef struct packed {
    logic [QUAL_W-1:0] qual;
    logic [AID_W-1:0]  aid;
  } slot_t;

  typedef enum logic [1:0] {LV_WHEEL, LV_PRIO, LV_RR1, LV_RR2} level_e;

  function automatic logic [31:0] slot_word(slot_t e);
    logic [31:0] w;
    w = '0;
    w[AID_W-1:0] = e.aid;
    w[8 +: QUAL_W] = e.qual;
    return w;
  endfunction
endpackage

// File: rtl/marb_tables.sv
module marb_tables
  import marb_pkg::*;
#(
  parameter int WHEEL_DEPTH = 128,
  parameter int PRIO_DEPTH  = 16,
  parameter int RR1_DEPTH   = 16,
  parameter int RR2_DEPTH   = 8,
  localparam int W_IDX_W  = $clog2(WHEEL_DEPTH),
  localparam int P_IDX_W  = $clog2(PRIO_DEPTH),
  localparam int R1_IDX_W = $clog2(RR1_DEPTH),
  localparam int R2_IDX_W = $clog2(RR2_DEPTH),
  localparam int WCNT_W   = W_IDX_W + 1,
  localparam int PCNT_W   = P_IDX_W + 1,
  localparam int R1CNT_W  = R1_IDX_W + 1,
  localparam int R2CNT_W  = R2_IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     set_sel,
  input  logic [W_IDX_W-1:0]       wheel_slot,
  output slot_t                    wheel_entry,
  output slot_t [PRIO_DEPTH-1:0]   prio_list,
  output slot_t [RR1_DEPTH-1:0]    rr1_list,
  output slot_t [RR2_DEPTH-1:0]    rr2_list,
  output logic [WCNT_W-1:0]        wheel_cnt,
  output logic [PCNT_W-1:0]        prio_cnt,
  output logic [R1CNT_W-1:0]       rr1_cnt,
  output logic [R2CNT_W-1:0]       rr2_cnt
);
  localparam int PRIO_BASE = 128;
  localparam int RR1_BASE  = PRIO_BASE + PRIO_DEPTH;
  localparam int RR2_BASE  = RR1_BASE + RR1_DEPTH;
  localparam int CNT_OFF   = 192;

  logic [7:0] off;
  logic       aset;
  slot_t      wr_slot;
  logic       in_wheel, in_prio, in_rr1, in_rr2, in_cnt;
  logic [7:0] prio_off, rr1_off, rr2_off;

  assign off      = cfg_addr[7:0];
  assign aset     = cfg_addr[8];
  assign wr_slot  = '{qual: cfg_wdata[8 +: QUAL_W], aid: cfg_wdata[AID_W-1:0]};
  assign in_wheel = int'(off) < WHEEL_DEPTH;
  assign in_prio  = int'(off) >= PRIO_BASE && int'(off) < RR1_BASE;
  assign in_rr1   = int'(off) >= RR1_BASE && int'(off) < RR2_BASE;
  assign in_rr2   = int'(off) >= RR2_BASE && int'(off) < RR2_BASE + RR2_DEPTH;
  assign in_cnt   = int'(off) == CNT_OFF;
  assign prio_off = off - 8'(PRIO_BASE);
  assign rr1_off  = off - 8'(RR1_BASE);
  assign rr2_off  = off - 8'(RR2_BASE);

  // wheel slots: plain memory, no reset, one write port
  slot_t wheel_mem [2*WHEEL_DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_we && in_wheel)
      wheel_mem[{aset, off[W_IDX_W-1:0]}] <= wr_slot;
  end

  slot_t [PRIO_DEPTH-1:0] prio_q [2];
  slot_t [RR1_DEPTH-1:0]  rr1_q  [2];
  slot_t [RR2_DEPTH-1:0]  rr2_q  [2];
  logic [WCNT_W-1:0]      wcnt_q [2];
  logic [PCNT_W-1:0]      pcnt_q [2];
  logic [R1CNT_W-1:0]     r1cnt_q[2];
  logic [R2CNT_W-1:0]     r2cnt_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        prio_q[s]  <= '0;
        rr1_q[s]   <= '0;
        rr2_q[s]   <= '0;
        wcnt_q[s]  <= '0;
        pcnt_q[s]  <= '0;
        r1cnt_q[s] <= '0;
        r2cnt_q[s] <= '0;
      end
    end else if (cfg_we) begin
      if (in_prio) prio_q[aset][prio_off[P_IDX_W-1:0]] <= wr_slot;
      if (in_rr1)  rr1_q[aset][rr1_off[R1_IDX_W-1:0]]  <= wr_slot;
      if (in_rr2)  rr2_q[aset][rr2_off[R2_IDX_W-1:0]]  <= wr_slot;
      if (in_cnt) begin
        r2cnt_q[aset] <= cfg_wdata[R2CNT_W-1:0];
        r1cnt_q[aset] <= cfg_wdata[8 +: R1CNT_W];
        pcnt_q[aset]  <= cfg_wdata[16 +: PCNT_W];
        wcnt_q[aset]  <= cfg_wdata[24 +: WCNT_W];
      end
    end
  end

  // registered readback; unmapped space and spare bits return zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= '0;
      if (in_wheel)     cfg_rdata <= slot_word(wheel_mem[{aset, off[W_IDX_W-1:0]}]);
      else if (in_prio) cfg_rdata <= slot_word(prio_q[aset][prio_off[P_IDX_W-1:0]]);
      else if (in_rr1)  cfg_rdata <= slot_word(rr1_q[aset][rr1_off[R1_IDX_W-1:0]]);
      else if (in_rr2)  cfg_rdata <= slot_word(rr2_q[aset][rr2_off[R2_IDX_W-1:0]]);
      else if (in_cnt) begin
        cfg_rdata[R2CNT_W-1:0]  <= r2cnt_q[aset];
        cfg_rdata[8 +: R1CNT_W] <= r1cnt_q[aset];
        cfg_rdata[16 +: PCNT_W] <= pcnt_q[aset];
        cfg_rdata[24 +: WCNT_W] <= wcnt_q[aset];
      end
    end
  end

  assign wheel_entry = wheel_mem[{set_sel, wheel_slot}];
  assign prio_list   = prio_q[set_sel];
  assign rr1_list    = rr1_q[set_sel];
  assign rr2_list    = rr2_q[set_sel];
  assign wheel_cnt   = wcnt_q[set_sel];
  assign prio_cnt    = pcnt_q[set_sel];
  assign rr1_cnt     = r1cnt_q[set_sel];
  assign rr2_cnt     = r2cnt_q[set_sel];

  // R12: a write to the count word is visible on the next read of it
  AST_CNT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    cfg_we && in_cnt && !aset |=> wcnt_q[0] == $past(cfg_wdata[24 +: WCNT_W])); // R12
endmodule

// File: rtl/marb_pick.sv
module marb_pick
  import marb_pkg::*;
#(
  parameter int N_AGENTS = 32,
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 5,
  parameter bit ROTATE   = 1'b1,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic [N_AGENTS-1:0] req,
  input  slot_t [DEPTH-1:0]   list,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [IDX_W-1:0]    start,
  output logic                hit,
  output logic [IDX_W-1:0]    idx,
  output logic [IDX_W-1:0]    after
);
  int eff;
  int base;

  assign eff = (int'(cnt) > DEPTH) ? DEPTH : int'(cnt);

  generate
    if (ROTATE) begin : g_rot
      assign base = (int'(start) < eff) ? int'(start) : 0;
    end else begin : g_fix
      assign base = 0;
    end
  endgenerate

  always_comb begin
    int j;
    hit = 1'b0;
    idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      j = base + k;
      if (j >= eff) j = j - eff;
      if (k < eff && req[list[IDX_W'(j)].aid]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end

  always_comb begin
    int nj;
    nj = int'(idx) + 1;
    after = (nj >= eff) ? '0 : IDX_W'(nj);
  end
endmodule

// File: rtl/marb_top.sv
module marb_top
  import marb_pkg::*;
#(
  parameter int N_AGENTS    = 32,
  parameter int WHEEL_DEPTH = 128,
  parameter int PRIO_DEPTH  = 16,
  parameter int RR1_DEPTH   = 16,
  parameter int RR2_DEPTH   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] req,
  input  logic [N_AGENTS-1:0] req_wr,
  input  logic                set_sel,
  input  logic                accept,
  output logic [N_AGENTS-1:0] grant,
  output logic                grant_valid,
  output logic [AID_W-1:0]    grant_id,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata
);
  localparam int W_IDX_W  = $clog2(WHEEL_DEPTH);
  localparam int P_IDX_W  = $clog2(PRIO_DEPTH);
  localparam int R1_IDX_W = $clog2(RR1_DEPTH);
  localparam int R2_IDX_W = $clog2(RR2_DEPTH);

  slot_t                     wheel_entry;
  slot_t [PRIO_DEPTH-1:0]    prio_list;
  slot_t [RR1_DEPTH-1:0]     rr1_list;
  slot_t [RR2_DEPTH-1:0]     rr2_list;
  logic [W_IDX_W:0]          wheel_cnt;
  logic [P_IDX_W:0]          prio_cnt;
  logic [R1_IDX_W:0]         rr1_cnt;
  logic [R2_IDX_W:0]         rr2_cnt;

  logic [W_IDX_W-1:0]  wptr, wslot, wnext, wnext_q;
  logic [R1_IDX_W-1:0] rr1_ptr, rr1_idx, rr1_after, rr1_nq;
  logic [R2_IDX_W-1:0] rr2_ptr, rr2_idx, rr2_after, rr2_nq;
  logic [P_IDX_W-1:0]  prio_idx, prio_after;
  logic                wheel_hit, prio_hit, rr1_hit, rr2_hit;
  logic                win;
  logic [AID_W-1:0]    win_id;
  level_e              win_lvl, lvl_q;

  // the qualifier has no code that filters by direction; req_wr is unused
  logic unused_wr;
  assign unused_wr = ^req_wr;

  marb_tables #(
    .WHEEL_DEPTH(WHEEL_DEPTH), .PRIO_DEPTH(PRIO_DEPTH),
    .RR1_DEPTH(RR1_DEPTH), .RR2_DEPTH(RR2_DEPTH)
  ) u_tables (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .set_sel(set_sel),
    .wheel_slot(wslot), .wheel_entry(wheel_entry), .prio_list(prio_list),
    .rr1_list(rr1_list), .rr2_list(rr2_list), .wheel_cnt(wheel_cnt),
    .prio_cnt(prio_cnt), .rr1_cnt(rr1_cnt), .rr2_cnt(rr2_cnt)
  );

  // wheel level: only the owner of the current slot is looked at
  always_comb begin
    int weff, nxt;
    weff = (int'(wheel_cnt) > WHEEL_DEPTH) ? WHEEL_DEPTH : int'(wheel_cnt);
    wslot = (int'(wptr) < weff) ? wptr : '0;
    nxt = int'(wslot) + 1;
    wnext = (nxt >= weff) ? '0 : W_IDX_W'(nxt);
    wheel_hit = (weff != 0) && req[wheel_entry.aid];
  end

  marb_pick #(.N_AGENTS(N_AGENTS), .DEPTH(PRIO_DEPTH), .CNT_W(P_IDX_W + 1), .ROTATE(1'b0))
  u_prio (.req(req), .list(prio_list), .cnt(prio_cnt), .start('0),
          .hit(prio_hit), .idx(prio_idx), .after(prio_after));

  marb_pick #(.N_AGENTS(N_AGENTS), .DEPTH(RR1_DEPTH), .CNT_W(R1_IDX_W + 1), .ROTATE(1'b1))
  u_rr1 (.req(req), .list(rr1_list), .cnt(rr1_cnt), .start(rr1_ptr),
         .hit(rr1_hit), .idx(rr1_idx), .after(rr1_after));

  marb_pick #(.N_AGENTS(N_AGENTS), .DEPTH(RR2_DEPTH), .CNT_W(R2_IDX_W + 1), .ROTATE(1'b1))
  u_rr2 (.req(req), .list(rr2_list), .cnt(rr2_cnt), .start(rr2_ptr),
         .hit(rr2_hit), .idx(rr2_idx), .after(rr2_after));

  logic unused_prio_after;
  assign unused_prio_after = ^prio_after;

  always_comb begin
    win     = 1'b1;
    win_lvl = LV_WHEEL;
    win_id  = wheel_entry.aid;
    if (wheel_hit) begin
      win_lvl = LV_WHEEL;
    end else if (prio_hit) begin
      win_lvl = LV_PRIO;
      win_id  = prio_list[prio_idx].aid;
    end else if (rr1_hit) begin
      win_lvl = LV_RR1;
      win_id  = rr1_list[rr1_idx].aid;
    end else if (rr2_hit) begin
      win_lvl = LV_RR2;
      win_id  = rr2_list[rr2_idx].aid;
    end else begin
      win = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant       <= '0;
      grant_id    <= '0;
      lvl_q       <= LV_WHEEL;
      wptr        <= '0;
      wnext_q     <= '0;
      rr1_ptr     <= '0;
      rr1_nq      <= '0;
      rr2_ptr     <= '0;
      rr2_nq      <= '0;
    end else if (grant_valid) begin
      if (accept) begin
        grant_valid <= 1'b0;
        grant       <= '0;
        wptr        <= wnext_q;
        if (lvl_q == LV_RR1) rr1_ptr <= rr1_nq;
        if (lvl_q == LV_RR2) rr2_ptr <= rr2_nq;
      end
    end else if (win) begin
      grant_valid <= 1'b1;
      grant       <= N_AGENTS'(1) << win_id;
      grant_id    <= win_id;
      lvl_q       <= win_lvl;
      wnext_q     <= wnext;
      rr1_nq      <= rr1_after;
      rr2_nq      <= rr2_after;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> $onehot(grant) && grant[grant_id]); // R10
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    grant_valid && !accept |=> grant_valid && $stable(grant_id)); // R10
  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (rst)
    grant_valid && accept |=> !grant_valid); // R10
  AST_IDLE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !grant_valid && req == '0 |=> !grant_valid); // R11
  AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> |($past(req) & grant)); // R2
  AST_WHEEL_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && accept) |=> $stable(wptr)); // R3
  AST_RR1_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && accept && lvl_q == LV_RR1) |=> $stable(rr1_ptr)); // R5
  AST_RR2_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && accept && lvl_q == LV_RR2) |=> $stable(rr2_ptr)); // R6
endmodule

// File: tb/tb_marb_top.sv
module tb_marb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  req_wr = '0;
  logic          set_sel = 1'b0;
  logic          accept = 1'b0;
  logic [N-1:0]  grant;
  logic          grant_valid;
  logic [4:0]    grant_id;
  logic          cfg_we = 1'b0;
  logic [8:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  marb_top dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .set_sel(set_sel),
    .accept(accept), .grant(grant), .grant_valid(grant_valid),
    .grant_id(grant_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [N-1:0] bits(input int a, input int b = -1, input int c = -1);
    logic [N-1:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // monitor: compares each accepted grant with the next scoreboard item
  always @(negedge clk) begin
    if (!rst && grant_valid && accept) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected grant", int'(grant_id), -1);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(int'(grant_id) == e, t, int'(grant_id), e);
        check(grant == (N'(1) << e), "R10 one-hot vector", int'(grant), int'(N'(1) << e));
      end
    end
  end

  task automatic cfg_write(input logic [8:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [8:0] a, input logic [31:0] e, input string tag);
    cfg_addr = a;
    @(posedge clk); #1;
    check(cfg_rdata == e, tag, int'(cfg_rdata), int'(e));
  endtask

  task automatic expect_grant(input logic [N-1:0] r, input logic [N-1:0] w,
                              input int e, input string tag, input int hold = 0);
    int c;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req = r; req_wr = w;
    c = 0;
    while (!grant_valid && c < 10) begin
      @(posedge clk); #1;
      c++;
    end
    if (!grant_valid) begin
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      check(1'b0, {tag, " no grant"}, 0, e);
      req = '0;
    end else begin
      req = '0;
      for (int h = 0; h < hold; h++) begin
        @(posedge clk); #1;
        check(grant_valid && int'(grant_id) == e, "R10 held without accept", int'(grant_id), e);
      end
      accept = 1'b1;
      @(posedge clk); #1;
      accept = 1'b0;
    end
  endtask

  task automatic expect_none(input logic [N-1:0] r, input string tag);
    req = r;
    repeat (4) @(posedge clk);
    #1;
    check(!grant_valid, tag, int'(grant_valid), 0);
    req = '0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check(!grant_valid, "R1 grant_valid after reset", int'(grant_valid), 0);
    check(grant == '0, "R1 grant after reset", int'(grant), 0);
    check(cfg_rdata == '0, "R1 rdata after reset", int'(cfg_rdata), 0);
    expect_none('1, "R1 counts zero after reset");

    // copy 0: wheel 3,5,7,9; priority 10,11,(12); list1 20,21,22,(23); list2 30,31
    cfg_write(9'h000, 32'd3);  cfg_write(9'h001, 32'd5);
    cfg_write(9'h002, 32'd7);  cfg_write(9'h003, 32'd9);
    cfg_write(9'h080, 32'd10); cfg_write(9'h081, 32'd11); cfg_write(9'h082, 32'd12);
    cfg_write(9'h090, 32'd20); cfg_write(9'h091, 32'd21);
    cfg_write(9'h092, 32'd22); cfg_write(9'h093, 32'd23);
    cfg_write(9'h0A0, 32'd30); cfg_write(9'h0A1, 32'd31);
    cfg_write(9'h0C0, 32'h04020302);

    expect_grant(bits(3, 10), '0, 3,  "R2 wheel owner beats priority");
    expect_grant(bits(5, 10), '0, 5,  "R3 slot 1 owner");
    expect_grant(bits(10),    '0, 10, "R3 slot 2 owner idle, priority serves");
    expect_grant(bits(9, 11), '0, 9,  "R3 slot 3 owner after non-wheel grant");
    expect_grant(bits(3),     '0, 3,  "R3 wrap to slot 0");
    expect_grant(bits(10, 11), '0, 10, "R4 lowest index wins");
    expect_grant(bits(11, 20), '0, 11, "R2 priority beats list 1", 2);
    expect_grant(bits(12, 20), '0, 20, "R4 entry beyond count skipped");
    expect_grant(bits(20, 21, 22), '0, 21, "R5 search after last grant");
    expect_grant(bits(20, 21, 22), '0, 22, "R5 rotation");
    expect_grant(bits(20, 21, 22), '0, 20, "R5 wrap at count");
    expect_grant(bits(22, 30), '0, 22, "R2 list 1 beats list 2");
    expect_none(bits(23), "R5 entry beyond count skipped");
    expect_grant(bits(30, 31), '0, 30, "R6 first list 2 grant");
    expect_grant(bits(30, 31), '0, 31, "R6 rotation");
    expect_grant(bits(30, 31), '0, 30, "R6 wrap at count");

    cfg_write(9'h0A7, 32'd29);
    cfg_write(9'h0C0, 32'h0402030F);
    expect_grant(bits(29), '0, 29, "R7 list 2 count 15 uses 8 entries");
    cfg_write(9'h08F, 32'd13);
    cfg_write(9'h0C0, 32'h041F030F);
    expect_grant(bits(13), '0, 13, "R7 priority count 31 uses 16 entries");

    cfg_write(9'h0C0, 32'h001F030F);
    expect_none(bits(3), "R3 wheel count zero disables wheel");

    cfg_write(9'h080, 32'h0000030A);
    expect_grant(bits(10), '0, 10, "R8 reserved qualifier, read");
    expect_grant(bits(10), '1, 10, "R8 reserved qualifier, write");
    expect_none('0, "R11 no request no grant");

    cfg_write(9'h105, 32'hFFFFFFFF);
    cfg_check(9'h105, 32'h0000031F, "R12 entry spare bits read zero");
    cfg_write(9'h1C0, 32'hFFFFFFFF);
    cfg_check(9'h1C0, 32'hFF1F1F0F, "R12 count word layout");
    cfg_write(9'h0B0, 32'hFFFFFFFF);
    cfg_check(9'h0B0, 32'h0, "R12 unmapped reads zero");
    cfg_check(9'h080, 32'h0000030A, "R12 qualifier readback");

    cfg_write(9'h180, 32'd15);
    cfg_write(9'h1C0, 32'h00010000);
    set_sel = 1'b1;
    expect_grant(bits(15, 10), '0, 15, "R9 copy 1 selected");
    set_sel = 1'b0;
    expect_grant(bits(15, 10), '0, 10, "R9 copy 0 selected");

    done = 1'b1;
    if (exp_q.size() != 0) check(1'b0, "R10 grants left unseen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule